// File: doc/BRIEF.md
# Frame Pulse Format Detector

This block sits between the frame synchronisation pin and the core of a time-slot switch. It runs on the 16.384 MHz serial clock. It finds the frame boundary and keeps a free-running bit position counter for the core. Once it is locked, it issues a one-clock start-of-frame strobe.

In short-pulse mode the block works out the pulse convention by itself. A short low-going pulse is classed as ST-BUS and a short high-going pulse as GCI. The block then requires a number of consecutive pulses, all with the same polarity and width and exactly one frame apart, before it declares lock. A missing pulse, an early or late pulse, a polarity change or a width change drops lock.

In wide-pulse mode a 4.096 MHz auxiliary clock, oversampled in the serial clock domain, qualifies the samples. The frame boundary is the first auxiliary sample that finds the negative wide pulse low after a high sample.

Top module: `frame_sync_detect`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `lock_o`, `sof_o` and `fmt_gci_o` are 0 and `pos_o` is 0.
- R2: `pos_o` advances by one every clock and wraps from FRAME_LEN-1 (2047) to 0. An accepted short pulse of w samples realigns it so that `pos_o` equals w in the cycle after the edge that sees the pulse end. Seen from the input, `pos_o` reads 0 in the cycle after the first active sample.
- R3: In short mode a pulse is a run of 1 to MAX_W (4) equal samples, with a level change on each side, the first of those changes seen after reset or after a mode change. A low run sets `fmt_gci_o` to 0 (ST-BUS) and a high run sets it to 1 (GCI). `fmt_gci_o` holds while lock holds.
- R4: `lock_o` rises in the cycle after the LOCK_FRAMES-th (3rd) consecutive pulse with the same polarity and width, each one exactly FRAME_LEN clocks after the previous one.
- R5: `sof_o` is high for exactly one clock, only while locked, in the cycle where `pos_o` is 0.
- R6: If the edge at which the next pulse should end passes without one, lock and the pulse count clear.
- R7: A pulse at any other spacing, or with a different polarity or width, clears lock, realigns `pos_o` to it and restarts the count at one.
- R8: A run longer than MAX_W samples has no effect on lock, alignment or format.
- R9: With `wide_mode_i` high, the short-pulse path is ignored. `fp_i` is sampled only at clock edges where `aux_clk_i` is newly high. A low sample after a high one sets `pos_o` to 0 in the following cycle, and lock forms under R4 with `fmt_gci_o` 0.
- R10: Any change of `wide_mode_i` clears lock and the pulse count in the following cycle, and discards any partial short run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_mode_i | input | 1 | 1 selects wide negative pulse alignment |
| fp_i | input | 1 | Frame pulse input, synchronous to clk_i |
| aux_clk_i | input | 1 | 4.096 MHz auxiliary clock, phase-locked to clk_i |
| sof_o | output | 1 | One-clock start-of-frame strobe |
| pos_o | output | 11 | Bit position in frame (channel and bit phase) |
| fmt_gci_o | output | 1 | Detected format: 0 ST-BUS, 1 GCI |
| lock_o | output | 1 | Frame alignment locked |

## Verification
Every result is a register or a decode of registers. In short mode a pulse ending at edge t moves `pos_o`, `fmt_gci_o` and `lock_o` in the cycle after edge t. In wide mode the aux-qualified falling sample at edge t sets `pos_o` to 0 in the cycle after t. `sof_o` is due in that same cycle whenever the block is locked. The bench drives inputs at the falling clock edge and advances a timestamp-based model for the rising edge that follows. It compares every output at the next falling edge, which keeps each check one register stage behind its stimulus. Milestone checks after each scenario confirm lock, loss of lock and the detected format.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  typedef enum logic {FMT_ST = 1'b0, FMT_GCI = 1'b1} fp_fmt_e;
endpackage

// File: rtl/fsd_short_det.sv
module fsd_short_det
  import fsd_pkg::*;
#(
  parameter int MAX_W = 4,
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic             restart_i,
  output logic             ev_o,
  output fp_fmt_e          ev_pol_o,
  output logic [LEN_W-1:0] ev_len_o
);
  localparam int RUN_W = $clog2(MAX_W + 2);
  localparam logic [RUN_W-1:0] SAT = RUN_W'(MAX_W + 1);

  logic             lvl_q;
  logic [RUN_W-1:0] run_q;
  logic             chg;

  assign chg      = fp_i != lvl_q;
  assign ev_o     = chg && (run_q <= RUN_W'(MAX_W)) && !restart_i;
  assign ev_pol_o = fp_fmt_e'(lvl_q);
  assign ev_len_o = LEN_W'(run_q);

  // run_q saturates at SAT: a run that long can no longer be a pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      run_q <= SAT;
    end else begin
      lvl_q <= fp_i;
      if (restart_i)       run_q <= SAT;
      else if (chg)        run_q <= RUN_W'(1);
      else if (run_q != SAT) run_q <= run_q + RUN_W'(1);
    end
  end
endmodule

// File: rtl/fsd_wide_det.sv
module fsd_wide_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fp_i,
  input  logic aux_clk_i,
  output logic ev_o
);
  logic aux_q, smp_q, aux_rise;

  assign aux_rise = aux_clk_i & ~aux_q;
  assign ev_o     = aux_rise & smp_q & ~fp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_q <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      aux_q <= aux_clk_i;
      if (aux_rise) smp_q <= fp_i;
    end
  end
endmodule

// File: rtl/fsd_track.sv
module fsd_track
  import fsd_pkg::*;
#(
  parameter int FRAME_LEN   = 2048,
  parameter int LOCK_FRAMES = 3,
  parameter int POS_W       = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             ev_i,
  input  fp_fmt_e          ev_pol_i,
  input  logic [POS_W-1:0] ev_len_i,
  output logic [POS_W-1:0] pos_o,
  output logic             lock_o,
  output fp_fmt_e          fmt_o
);
  localparam int CH_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [CH_W-1:0]  CH_MAX = CH_W'(LOCK_FRAMES);
  localparam logic [POS_W-1:0] LAST   = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] cnt_q, nxt, len_q;
  logic [CH_W-1:0]  chain_q, chain_nx;
  fp_fmt_e          pol_q;
  logic             lock_q, match, due;

  assign nxt      = (cnt_q == LAST) ? '0 : cnt_q + POS_W'(1);
  assign chain_nx = (chain_q == CH_MAX) ? chain_q : chain_q + CH_W'(1);
  assign due      = (chain_q != '0) && (nxt == len_q);
  assign match    = due && (ev_pol_i == pol_q) && (ev_len_i == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      chain_q <= '0;
      pol_q   <= FMT_ST;
      len_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      cnt_q <= ev_i ? ev_len_i : nxt;
      if (flush_i) begin
        chain_q <= '0;
        lock_q  <= 1'b0;
      end else if (ev_i && match) begin
        chain_q <= chain_nx;
        if (chain_nx >= CH_MAX) lock_q <= 1'b1;
      end else if (ev_i) begin
        chain_q <= CH_W'(1);
        pol_q   <= ev_pol_i;
        len_q   <= ev_len_i;
        lock_q  <= (LOCK_FRAMES <= 1);
      end else if (due) begin
        chain_q <= '0;
        lock_q  <= 1'b0;
      end
    end
  end

  assign pos_o  = cnt_q;
  assign lock_o = lock_q;
  assign fmt_o  = pol_q;
endmodule

// File: rtl/frame_sync_detect.sv
module frame_sync_detect
  import fsd_pkg::*;
#(
  parameter int FRAME_LEN   = 2048,
  parameter int MAX_W       = 4,
  parameter int LOCK_FRAMES = 3,
  localparam int POS_W      = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_mode_i,
  input  logic             fp_i,
  input  logic             aux_clk_i,
  output logic             sof_o,
  output logic [POS_W-1:0] pos_o,
  output logic             fmt_gci_o,
  output logic             lock_o
);
  logic             mode_q, flush;
  logic             s_ev, w_ev, ev;
  fp_fmt_e          s_pol, ev_pol, fmt;
  logic [POS_W-1:0] s_len, ev_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= wide_mode_i;
  end
  assign flush = wide_mode_i != mode_q;

  fsd_short_det #(.MAX_W(MAX_W), .LEN_W(POS_W)) u_short (
    .clk_i, .rst_ni, .fp_i, .restart_i(flush),
    .ev_o(s_ev), .ev_pol_o(s_pol), .ev_len_o(s_len)
  );

  fsd_wide_det u_wide (
    .clk_i, .rst_ni, .fp_i, .aux_clk_i, .ev_o(w_ev)
  );

  // wide boundary is pos 0 with fixed negative polarity
  assign ev     = !flush && (wide_mode_i ? w_ev : s_ev);
  assign ev_pol = wide_mode_i ? FMT_ST : s_pol;
  assign ev_len = wide_mode_i ? '0 : s_len;

  fsd_track #(.FRAME_LEN(FRAME_LEN), .LOCK_FRAMES(LOCK_FRAMES), .POS_W(POS_W)) u_track (
    .clk_i, .rst_ni, .flush_i(flush), .ev_i(ev), .ev_pol_i(ev_pol),
    .ev_len_i(ev_len), .pos_o, .lock_o, .fmt_o(fmt)
  );

  assign sof_o     = lock_o && (pos_o == '0);
  assign fmt_gci_o = (fmt == FMT_GCI);
endmodule

// File: rtl/frame_sync_detect_chk.sv
module frame_sync_detect_chk #(
  parameter int FRAME_LEN   = 2048,
  parameter int LOCK_FRAMES = 3,
  localparam int POS_W      = $clog2(FRAME_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wide_mode_i,
  input logic             sof_o,
  input logic [POS_W-1:0] pos_o,
  input logic             fmt_gci_o,
  input logic             lock_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  // R5
  sof_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> lock_o);
  // R5
  sof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);
  // R2
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |->
      (pos_o == (($past(pos_o) == LAST) ? '0 : $past(pos_o) + POS_W'(1))));
  // R3
  fmt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LOCK_FRAMES > 1 && lock_o && $past(lock_o)) |-> $stable(fmt_gci_o));
  // R10
  mode_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode_i != $past(wide_mode_i)) |=> !lock_o);
  // R9
  wide_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode_i && $past(wide_mode_i) && lock_o) |-> !fmt_gci_o);
endmodule

bind frame_sync_detect frame_sync_detect_chk #(
  .FRAME_LEN(FRAME_LEN), .LOCK_FRAMES(LOCK_FRAMES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wide_mode_i(wide_mode_i), .sof_o(sof_o),
  .pos_o(pos_o), .fmt_gci_o(fmt_gci_o), .lock_o(lock_o)
);

// File: tb/frame_sync_detect_tb.sv
`timescale 1ns/1ps
module frame_sync_detect_tb;
  localparam int F = 2048;
  localparam int MW = 4;
  localparam int L = 3;

  logic clk = 1'b0, rst_ni = 1'b0, wide = 1'b0, fp = 1'b1, aux = 1'b0;
  logic sof_o, fmt_gci_o, lock_o;
  logic [10:0] pos_o;

  always #2 clk = ~clk;

  frame_sync_detect u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wide_mode_i(wide), .fp_i(fp), .aux_clk_i(aux),
    .sof_o(sof_o), .pos_o(pos_o), .fmt_gci_o(fmt_gci_o), .lock_o(lock_o)
  );

  int nchk = 0, nbad = 0, gcyc = 0, sof_cnt = 0;
  bit done = 0;

  // behavioural model: timestamps instead of counters
  int t = 0, origin = 0, chain = 0, mlen = 0, last_chg = -1;
  bit mlock = 0, mpol = 0, prev_lvl = 1, mode_prev = 0, aux_prev = 0, wsmp = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, gcyc);
    end
  endtask

  task automatic model_step(input bit w, input bit f, input bit a);
    bit ev, ep, flush, rise;
    int ew, p;
    t++;
    ev = 0; ep = 0; ew = 0;
    flush = (w != mode_prev);
    mode_prev = w;
    if (f != prev_lvl) begin
      if (!flush && !w && last_chg >= 0 && (t - last_chg) <= MW) begin
        ev = 1; ew = t - last_chg; ep = prev_lvl;
      end
      last_chg = flush ? -1 : t;
    end else if (flush) last_chg = -1;
    prev_lvl = f;
    rise = a && !aux_prev;
    aux_prev = a;
    if (rise) begin
      if (!flush && w && wsmp && !f) begin ev = 1; ew = 0; ep = 0; end
      wsmp = f;
    end
    p = (t - origin) % F;
    if (flush) begin
      chain = 0; mlock = 0;
    end else if (ev && chain > 0 && ep == mpol && ew == mlen && p == mlen) begin
      chain = (chain < L) ? chain + 1 : L;
      mlock = (chain >= L);
    end else if (ev) begin
      chain = 1; origin = t - ew; mpol = ep; mlen = ew; mlock = (L <= 1);
    end else if (chain > 0 && p == mlen) begin
      chain = 0; mlock = 0;
    end
  endtask

  // at a falling edge: compare, drive, step model, go to next falling edge
  task automatic cycle(input bit w, input bit f);
    int ep;
    ep = (t - origin) % F;
    chk("R2", "pos", int'(pos_o), ep);
    chk("R4", "lock", int'(lock_o), int'(mlock));
    chk("R3", "fmt", int'(fmt_gci_o), int'(mpol));
    chk("R5", "sof", int'(sof_o), int'(mlock && ep == 0));
    if (sof_o) sof_cnt++;
    wide = w; fp = f; aux = (gcyc % 4) < 2;
    model_step(w, f, aux);
    gcyc++;
    @(negedge clk);
  endtask

  task automatic seg(input int n, input bit w, input int per, input int wid, input bit act,
                     input int skip, input int xs, input int xl);
    for (int i = 0; i < n; i++) begin
      bit pul;
      int ph;
      ph = i % per;
      pul = (ph < wid) && ((i / per) != skip);
      if (xs >= 0 && ph >= xs && ph < xs + xl) pul = 1;
      cycle(w, pul ? act : ~act);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "lock", int'(lock_o), 0);
    chk("R1", "sof", int'(sof_o), 0);
    chk("R1", "fmt", int'(fmt_gci_o), 0);
    chk("R1", "pos", int'(pos_o), 0);
    rst_ni = 1'b1;

    sof_cnt = 0;
    seg(5*F, 0, F, 1, 0, -1, -1, 0);               // ST-BUS, 1-sample low pulses
    chk("R4", "lock after ST frames", int'(lock_o), 1);
    chk("R3", "ST format", int'(fmt_gci_o), 0);
    chk("R5", "sof count", sof_cnt, 2);

    seg(3*F, 0, F, 1, 0, 1, -1, 0);                // one pulse missing
    chk("R6", "lock after missing pulse", int'(lock_o), 0);

    seg(3*F, 0, F, 1, 0, -1, -1, 0);
    chk("R4", "relock", int'(lock_o), 1);

    seg(F-1, 0, F-1, 1, 0, -1, -1, 0);             // next pulse one clock early
    seg(2*F, 0, F, 1, 0, -1, -1, 0);
    chk("R7", "lock after wrong spacing", int'(lock_o), 0);
    seg(3*F, 0, F, 1, 0, -1, -1, 0);
    chk("R7", "relock after restart", int'(lock_o), 1);

    seg(4*F, 0, F, 2, 1, -1, -1, 0);               // GCI, 2-sample high pulses
    chk("R3", "GCI format", int'(fmt_gci_o), 1);
    chk("R4", "lock on GCI", int'(lock_o), 1);

    seg(2*F, 0, F, 2, 1, -1, 700, MW+2);           // long run ignored
    chk("R8", "lock kept over long run", int'(lock_o), 1);
    chk("R8", "fmt kept over long run", int'(fmt_gci_o), 1);

    seg(F, 0, F, 2, 1, -1, 700, MW);               // max-width extra pulse
    chk("R7", "lock after stray pulse", int'(lock_o), 0);

    seg(5*F, 1, F, 16, 0, -1, -1, 0);              // wide negative pulses
    chk("R9", "wide lock", int'(lock_o), 1);
    chk("R9", "wide fmt", int'(fmt_gci_o), 0);

    seg(1, 0, F, 1, 1, -1, -1, 0);                 // back to short mode
    chk("R10", "lock after mode change", int'(lock_o), 0);
    seg(4*F, 0, F, 1, 0, -1, -1, 0);
    chk("R4", "lock in short mode again", int'(lock_o), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule